// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer on a small 32-bit register port. A 16-bit down counter advances on a tick enable. The tick comes from a two-stage chain clocked by the source clock: an 8-bit programmable prescaler, then a fixed divider of 16, 32, 64 or 128. When a tick arrives and the counter already stands at zero, the counter reloads from the reload register. On that expiry the block can latch a pending interrupt, emit a one-cycle reset request, or do both, depending on two enable bits.

Software keeps the system alive by writing the counter register before it runs out. It acknowledges the interrupt by writing any value to the write-only clear location. It stops the timer by writing zero to the control register.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0 (timer stopped). The reload register and the counter both read 0x8000. `irq` and `rst_req` are low.
- R2: Register word offsets are 0x0 for control, 0x4 for reload, 0x8 for counter and 0xC for interrupt clear. The control fields are: bit 0 reset-request enable, bit 2 interrupt enable, bits 4:3 divider code, bit 5 run, and bits 15:8 prescaler value P. All other control bits read as 0. Reload and counter read back their low 16 bits, zero-extended.
- R3: While running, one tick occurs every (P+1)×D source cycles, where D is 16, 32, 64 or 128 for divider codes 0, 1, 2 and 3. The first tick lands (P+1)×D cycles after the control write that starts the timer.
- R4: A tick that finds the counter nonzero decrements it by one. A tick that finds it at zero reloads it from the reload register and is an expiry. From a loaded value N, expiry therefore comes on tick N+1.
- R5: A write to the counter register loads the written value and cancels any tick in the same cycle. Rewriting it periodically prevents expiry.
- R6: An expiry with interrupt enable set makes `irq` pending. `irq` stays high, even if the timer is stopped, until a write to the clear location, whatever the data. If an expiry and a clear happen in the same cycle, the expiry wins.
- R7: An expiry with reset-request enable set raises `rst_req` for exactly one cycle. With that enable clear, no pulse appears.
- R8: With the run bit clear, the counter holds its value and no expiry occurs. The prescaler and divider restart from zero when the timer is started again.
- R9: Reads of the clear location return 0. Writes to it change neither the control, reload nor counter contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 pick the register, bits 1:0 must be zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current address |
| irq | output | 1 | Pending expiry interrupt |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The assertions rely on the tick chain never ticking on two cycles in a row. This holds because the smallest divider is 16. They also rely on a bus write lasting a single cycle and on the clear location being decoded only at an aligned address. The bench issues every access as a one-cycle strobe at aligned offsets. It changes the control register only between measured intervals, so no expiry coincides with a clear or a reconfiguration. Expected tick counts are computed from (P+1)×D in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int BUS_W      = 32;
    localparam int PRE_W      = 8;
    localparam int DSEL_W     = 2;
    localparam int DIV_CNT_W  = 7;
    localparam int DIV_MIN    = 16;

    // control field positions (software visible)
    localparam int CTL_RSTEN_BIT = 0;
    localparam int CTL_IRQEN_BIT = 2;
    localparam int CTL_DSEL_LO   = 3;
    localparam int CTL_RUN_BIT   = 5;
    localparam int CTL_PRE_LO    = 8;

    typedef enum logic [1:0] {
        REG_CTL = 2'd0,
        REG_RLD = 2'd1,
        REG_CNT = 2'd2,
        REG_CLR = 2'd3
    } wdog_reg_e;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DSEL_W-1:0] dsel;
        logic              run;
        logic              irq_en;
        logic              rst_en;
    } wdog_ctl_t;

    function automatic logic [BUS_W-1:0] ctl_to_word(wdog_ctl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CTL_PRE_LO +: PRE_W]   = c.pre;
        w[CTL_DSEL_LO +: DSEL_W] = c.dsel;
        w[CTL_RUN_BIT]           = c.run;
        w[CTL_IRQEN_BIT]         = c.irq_en;
        w[CTL_RSTEN_BIT]         = c.rst_en;
        return w;
    endfunction

    function automatic wdog_ctl_t word_to_ctl(logic [BUS_W-1:0] w);
        wdog_ctl_t c;
        c.pre    = w[CTL_PRE_LO +: PRE_W];
        c.dsel   = w[CTL_DSEL_LO +: DSEL_W];
        c.run    = w[CTL_RUN_BIT];
        c.irq_en = w[CTL_IRQEN_BIT];
        c.rst_en = w[CTL_RSTEN_BIT];
        return c;
    endfunction

    // terminal value of the fixed divider: divisor minus one
    function automatic logic [DIV_CNT_W-1:0] div_last(logic [DSEL_W-1:0] sel);
        return DIV_CNT_W'((32'(DIV_MIN) << sel) - 32'd1);
    endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter int          ADDR_W  = 4,
    parameter logic [15:0] RST_VAL = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output logic [BUS_W-1:0]  bus_rdata,
    output wdog_ctl_t         ctl,
    output logic [CNT_W-1:0]  rld,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              clr_wr
);

    wdog_reg_e idx;
    logic      aligned;
    logic      wr_hit;
    logic      unused_wdata;

    assign idx          = wdog_reg_e'(bus_addr[3:2]);
    assign aligned      = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
    assign wr_hit       = bus_valid && bus_write && aligned;
    assign cnt_wr       = wr_hit && (idx == REG_CNT);
    assign clr_wr       = wr_hit && (idx == REG_CLR);
    assign cnt_wdata    = bus_wdata[CNT_W-1:0];
    assign unused_wdata = ^bus_wdata[BUS_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
            rld <= CNT_W'(RST_VAL);
        end else if (wr_hit) begin
            if (idx == REG_CTL) ctl <= word_to_ctl(bus_wdata);
            if (idx == REG_RLD) rld <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                REG_CTL: bus_rdata = ctl_to_word(ctl);
                REG_RLD: bus_rdata = BUS_W'(rld);
                REG_CNT: bus_rdata = BUS_W'(cnt_val);
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [PRE_W-1:0]  pre,
    input  logic [DSEL_W-1:0] dsel,
    output logic              tick
);

    logic [PRE_W-1:0]     pre_cnt;
    logic [DIV_CNT_W-1:0] div_cnt;
    logic                 pre_hit;
    logic                 div_hit;

    // >= keeps the chain safe when a smaller limit is written mid-count
    assign pre_hit = run && (pre_cnt >= pre);
    assign div_hit = (div_cnt >= div_last(dsel));
    assign tick    = pre_hit && div_hit;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_hit) begin
            pre_cnt <= '0;
            div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int          CNT_W   = 16,
    parameter logic [15:0] RST_VAL = 16'h8000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             irq_en,
    input  logic             rst_en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] rld,
    input  logic             clr_wr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq,
    output logic             rst_req
);

    logic step;
    logic expire;

    assign step   = tick && !cnt_wr;
    assign expire = step && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (cnt_wr) begin
            cnt_q <= cnt_wdata;
        end else if (step) begin
            cnt_q <= expire ? rld : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (expire && irq_en) begin
            irq <= 1'b1;
        end else if (clr_wr) begin
            irq <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rst_req <= 1'b0;
        else     rst_req <= expire && rst_en;
    end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter int          ADDR_W  = 4,
    parameter logic [15:0] RST_VAL = 16'h8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    wdog_ctl_t        ctl;
    logic [CNT_W-1:0] rld;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_wdata;
    logic             cnt_wr;
    logic             clr_wr;
    logic             tick;

    wdog_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .RST_VAL(RST_VAL)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_val   (cnt_q),
        .bus_rdata (bus_rdata),
        .ctl       (ctl),
        .rld       (rld),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .clr_wr    (clr_wr)
    );

    wdog_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (ctl.run),
        .pre  (ctl.pre),
        .dsel (ctl.dsel),
        .tick (tick)
    );

    wdog_core #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .irq_en    (ctl.irq_en),
        .rst_en    (ctl.rst_en),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .rld       (rld),
        .clr_wr    (clr_wr),
        .cnt_q     (cnt_q),
        .irq       (irq),
        .rst_req   (rst_req)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              rst_req,
    input logic              tick,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input logic              cnt_wr,
    input logic              clr_wr
);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R3

    AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));  // R4

    AST_CNT_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt));  // R8

    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick);  // R8

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_wr) |=> irq);  // R6

    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !tick) |=> !irq);  // R6

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);  // R7

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr == ADDR_W'(12)) |-> (bus_rdata == 32'd0));  // R9

endmodule

bind wdog_timer wdog_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .rst_req   (rst_req),
    .tick      (tick),
    .run       (ctl.run),
    .cnt       (cnt_q),
    .cnt_wr    (cnt_wr),
    .clr_wr    (clr_wr)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;

    localparam logic [3:0] A_CTL = 4'h0;
    localparam logic [3:0] A_RLD = 4'h4;
    localparam logic [3:0] A_CNT = 4'h8;
    localparam logic [3:0] A_CLR = 4'hC;
    localparam logic [31:0] C_RUN = 32'h20;
    localparam logic [31:0] C_IRQ = 32'h04;
    localparam logic [31:0] C_RST = 32'h01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    int rst_pulses = 0;

    always #2.5 clk = ~clk;

    wdog_timer dut (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    always @(negedge clk) if (!rst && rst_req) rst_pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts clock edges from the last write until irq is seen
    task automatic wait_irq(output int n);
        n = 0;
        while (n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (irq) break;
        end
    endtask

    task automatic stop_and_clear();
        wr(A_CTL, 32'h0);
        wr(A_CLR, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTL, v); chk("R1 ctl", v, 32'h0);
        rd(A_RLD, v); chk("R1 rld", v, 32'h8000);
        rd(A_CNT, v); chk("R1 cnt", v, 32'h8000);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(A_CTL, 32'hFFFF_FF1F);
        rd(A_CTL, v); chk("R2 ctl fields", v, 32'h0000_FF1D);
        wr(A_RLD, 32'h1234_5678);
        rd(A_RLD, v); chk("R2 rld", v, 32'h5678);
        wr(A_CNT, 32'hCAFE_0ABC);
        rd(A_CNT, v); chk("R2 cnt", v, 32'h0ABC);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_period(input int p, input int sel);
        int n;
        int expd;
        expd = (p + 1) * (16 << sel);
        wr(A_CNT, 32'h0);
        wr(A_CTL, C_RUN | C_IRQ | (32'(sel) << 3) | (32'(p) << 8));
        wait_irq(n);
        chk("R3 tick period", 32'(n), 32'(expd));
        stop_and_clear();
    endtask

    task automatic t_reload();
        logic [31:0] v;
        int n;
        wr(A_RLD, 32'd3);
        wr(A_CNT, 32'd2);
        wr(A_CTL, C_RUN | C_IRQ);
        idle(20);
        rd(A_CNT, v); chk("R4 decrement", v, 32'd1);
        wait_irq(n);
        chk("R4 expiry on tick N+1", 32'(n + 21), 32'd48);
        rd(A_CNT, v); chk("R4 reload", v, 32'd3);
    endtask

    task automatic t_irq_clear();
        logic [31:0] v;
        wr(A_CTL, C_IRQ);
        idle(100);
        chk("R6 irq held while stopped", {31'b0, irq}, 32'h1);
        rd(A_CLR, v); chk("R9 clr reads zero", v, 32'h0);
        wr(A_CLR, 32'hDEAD_BEEF);
        chk("R6 irq cleared", {31'b0, irq}, 32'h0);
        rd(A_RLD, v); chk("R9 rld untouched", v, 32'd3);
        rd(A_CTL, v); chk("R9 ctl untouched", v, C_IRQ);
        chk("R7 no pulse without enable", 32'(rst_pulses), 32'd0);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_reset_req();
        wr(A_RLD, 32'd5);
        wr(A_CNT, 32'd1);
        rst_pulses = 0;
        wr(A_CTL, C_RUN | C_RST);
        idle(40);
        chk("R7 one pulse", 32'(rst_pulses), 32'd1);
        chk("R7 irq stays low", {31'b0, irq}, 32'h0);
        stop_and_clear();
    endtask

    task automatic t_keepalive();
        rst_pulses = 0;
        wr(A_CNT, 32'd10);
        wr(A_CTL, C_RUN | C_IRQ | C_RST);
        for (int i = 0; i < 10; i++) begin
            idle(100);
            wr(A_CNT, 32'd10);
        end
        chk("R5 no irq with keepalive", {31'b0, irq}, 32'h0);
        chk("R5 no reset with keepalive", 32'(rst_pulses), 32'd0);
    endtask

    task automatic t_disable();
        logic [31:0] a;
        logic [31:0] b;
        int n;
        wr(A_CTL, 32'h0);
        rd(A_CNT, a);
        idle(300);
        rd(A_CNT, b);
        chk("R8 counter frozen", b, a);
        chk("R8 no irq stopped", {31'b0, irq}, 32'h0);
        chk("R8 no reset stopped", 32'(rst_pulses), 32'd0);
        wr(A_CNT, 32'h0);
        wr(A_CTL, C_RUN | C_IRQ);
        wait_irq(n);
        chk("R8 prescaler restarts", 32'(n), 32'd16);
        stop_and_clear();
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_period(0, 0);
        t_period(1, 1);
        t_period(0, 2);
        t_period(2, 3);
        t_reload();
        t_irq_clear();
        t_reset_req();
        t_keepalive();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule